// File: doc/BRIEF.md
# Dual-Chain Bidirectional Latched Output Driver

This block turns a serial bit stream into a wide bank of latched, blankable output enables for a display or print-head driver. The register is split into two chains of equal length. Both chains advance on the same rising clock edge, so each edge loads two bits. Chain 0 feeds the lower half of the outputs and chain 1 feeds the upper half.

A direction input picks which way the data moves. It also picks which end of each chain takes serial data in and which end drives the cascade output toward the next device. The non-driving end reports a low output-enable and drives 0.

A transparent latch bank sits between the chains and the output stage. While the latch enable is high, the outputs follow the chains. While it is low, they keep the last value passed through. An active-low blanking input forces every output on. Otherwise each output is the inverse of its latched bit.

Top module: `dual_chain_driver`

## Requirements
- R1: Chain 0 maps to `out_en[CHAIN_LEN-1:0]` and chain 1 maps to `out_en[2*CHAIN_LEN-1:CHAIN_LEN]`. Both chains advance one stage on every rising clock edge, so one edge loads two bits.
- R2: With `dir_fwd`=1, `a_in[0]` enters chain 0 at index 0 and `a_in[1]` enters chain 1 at index `CHAIN_LEN`. Existing bits move one index upward.
- R3: With `dir_fwd`=0, `b_in[0]` enters chain 0 at index `CHAIN_LEN-1` and `b_in[1]` enters chain 1 at index `2*CHAIN_LEN-1`. Existing bits move one index downward.
- R4: With `dir_fwd`=1, `b_oe`=1, `a_oe`=0, `a_out`=0, and `b_out[g]` shows the top stage of chain g. With `dir_fwd`=0, `a_oe`=1, `b_oe`=0, `b_out`=0, and `a_out[g]` shows the bottom stage of chain g.
- R5: While `latch_en` is high, the latched view equals the chain contents as they stand after each edge.
- R6: While `latch_en` is low, the latched view holds the value it had when `latch_en` was last high.
- R7: While `blank_n` is 0, every bit of `out_en` is 1, whatever the latched data.
- R8: While `blank_n` is 1, `out_en[i]` is the inverse of latched bit i (1 means on).
- R9: Shifting goes on unchanged whatever the values of `latch_en` and `blank_n`.
- R10: A low `rst_n` at a rising edge synchronously clears both chains and the latch bank to 0. After reset, with `blank_n`=1, all outputs are on and the active cascade outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_fwd | input | 1 | 1: shift toward higher index; 0: toward lower index |
| latch_en | input | 1 | 1: latch transparent; 0: latch holds |
| blank_n | input | 1 | 0: force all outputs on |
| a_in | input | 2 | Low-end serial inputs, bit g for chain g |
| b_in | input | 2 | High-end serial inputs, bit g for chain g |
| a_out | output | 2 | Low-end cascade outputs (reverse direction) |
| b_out | output | 2 | High-end cascade outputs (forward direction) |
| a_oe | output | 1 | Low end is driving its cascade output |
| b_oe | output | 1 | High end is driving its cascade output |
| out_en | output | 2*CHAIN_LEN | Output enables, 1 = on |

## Verification
A rising edge moves the chains. The cascade outputs show the result in the same cycle, since they come straight from the chain registers. `out_en` shows it in the same cycle too, as long as `latch_en` is high. `blank_n`, `latch_en` and `dir_fwd` act on the outputs with no register in the path. The bench drives every input at the falling edge and updates its own reference after the rising edge. It compares all outputs at the next falling edge, which is half a cycle after the edge that produced them, so each check samples exactly one shift.

// File: rtl/dual_chain_driver.sv
module dual_chain_driver #(
  parameter int CHAIN_LEN = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dir_fwd,
  input  logic                   latch_en,
  input  logic                   blank_n,
  input  logic [1:0]             a_in,
  input  logic [1:0]             b_in,
  output logic [1:0]             a_out,
  output logic [1:0]             b_out,
  output logic                   a_oe,
  output logic                   b_oe,
  output logic [2*CHAIN_LEN-1:0] out_en
);
  localparam int WIDTH = 2 * CHAIN_LEN;

  logic [1:0][CHAIN_LEN-1:0] chain_q, chain_d;
  logic [WIDTH-1:0]          hold_q, shown;

  for (genvar g = 0; g < 2; g++) begin : g_chain
    assign chain_d[g] = dir_fwd ? {chain_q[g][CHAIN_LEN-2:0], a_in[g]}
                                : {b_in[g], chain_q[g][CHAIN_LEN-1:1]};
    assign a_out[g] = dir_fwd ? 1'b0 : chain_q[g][0];
    assign b_out[g] = dir_fwd ? chain_q[g][CHAIN_LEN-1] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      hold_q  <= '0;
    end else begin
      chain_q <= chain_d;
      if (latch_en) hold_q <= chain_d;
    end
  end

  assign shown  = latch_en ? chain_q : hold_q;
  assign out_en = blank_n ? ~shown : '1;
  assign a_oe   = ~dir_fwd;
  assign b_oe   = dir_fwd;
endmodule

// File: rtl/dual_chain_driver_chk.sv
module dual_chain_driver_chk #(
  parameter int CHAIN_LEN = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   dir_fwd,
  input logic                   latch_en,
  input logic                   blank_n,
  input logic [1:0]             a_in,
  input logic [1:0]             b_in,
  input logic [1:0]             a_out,
  input logic [1:0]             b_out,
  input logic                   a_oe,
  input logic                   b_oe,
  input logic [2*CHAIN_LEN-1:0] out_en,
  input logic [2*CHAIN_LEN-1:0] chain_flat
);
  localparam int CL = CHAIN_LEN;
  localparam int W  = 2 * CHAIN_LEN;

  p_fwd_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dir_fwd)) |->
      (chain_flat[CL-1:0] == {$past(chain_flat[CL-2:0]), $past(a_in[0])}) &&
      (chain_flat[W-1:CL] == {$past(chain_flat[W-2:CL]), $past(a_in[1])}));

  p_rev_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dir_fwd)) |->
      (chain_flat[CL-1:0] == {$past(b_in[0]), $past(chain_flat[CL-1:1])}) &&
      (chain_flat[W-1:CL] == {$past(b_in[1]), $past(chain_flat[W-1:CL+1])}));

  p_fwd_cascade_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fwd |-> (b_oe && !a_oe && a_out == 2'b00 &&
                 b_out == {chain_flat[W-1], chain_flat[CL-1]}));

  p_rev_cascade_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_fwd |-> (a_oe && !b_oe && b_out == 2'b00 &&
                  a_out == {chain_flat[CL], chain_flat[0]}));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !latch_en && !$past(latch_en) && blank_n && $past(blank_n))
      |-> $stable(out_en));

  p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (&out_en));

  p_polarity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && latch_en) |-> (out_en == ~chain_flat));

  p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) == 1'b0) |-> (chain_flat == '0));
endmodule

bind dual_chain_driver dual_chain_driver_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .latch_en(latch_en),
  .blank_n(blank_n), .a_in(a_in), .b_in(b_in), .a_out(a_out),
  .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe), .out_en(out_en),
  .chain_flat(chain_q)
);

// File: tb/sim_dual_chain_driver.sv
module sim_dual_chain_driver;
  localparam int CL = 32;
  localparam int W  = 2 * CL;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, dir_fwd, latch_en, blank_n;
  logic [1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe;
  logic [W-1:0] out_en;

  dual_chain_driver #(.CHAIN_LEN(CL)) u0 (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .latch_en(latch_en),
    .blank_n(blank_n), .a_in(a_in), .b_in(b_in), .a_out(a_out),
    .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe), .out_en(out_en)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [W-1:0] m_chain = '0;
  logic [W-1:0] m_hold  = '0;
  logic [15:0]  lfsr    = 16'hACE1;

  task automatic cmp(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_out();
    logic [W-1:0] v;
    v = latch_en ? m_chain : m_hold;
    return blank_n ? ~v : '1;
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      m_chain = '0;
      m_hold  = '0;
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        if (dir_fwd) begin
          for (int i = CL - 1; i > 0; i--) m_chain[ch*CL+i] = m_chain[ch*CL+i-1];
          m_chain[ch*CL] = a_in[ch];
        end else begin
          for (int i = 0; i < CL - 1; i++) m_chain[ch*CL+i] = m_chain[ch*CL+i+1];
          m_chain[ch*CL+CL-1] = b_in[ch];
        end
      end
      if (latch_en) m_hold = m_chain;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [1:0] ea, eb;
    ea = dir_fwd ? 2'b00 : {m_chain[CL], m_chain[0]};
    eb = dir_fwd ? {m_chain[W-1], m_chain[CL-1]} : 2'b00;
    cmp(req, "out_en", out_en, exp_out());
    cmp("R4", "a_out", W'(a_out), W'(ea));
    cmp("R4", "b_out", W'(b_out), W'(eb));
    cmp("R4", "oe", W'({a_oe, b_oe}), W'({~dir_fwd, dir_fwd}));
  endtask

  task automatic run(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a_in = lfsr[1:0];
      b_in = lfsr[3:2];
      tick();
      check_all(req);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dir_fwd = 1'b1; latch_en = 1'b0; blank_n = 1'b1;
    a_in = 2'b00; b_in = 2'b00;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    cmp("R10", "out_en after reset", out_en, '1);
    cmp("R10", "cascade after reset", W'({a_out, b_out}), '0);

    latch_en = 1'b1; a_in = 2'b11;
    tick();
    cmp("R1", "two bits per edge", out_en, ~((W'(1) << CL) | W'(1)));
    a_in = 2'b00;
    tick();
    cmp("R2", "forward move", out_en, ~((W'(2) << CL) | W'(2)));

    run(80, "R2 R5 R8");
    latch_en = 1'b0; run(40, "R6 R9");
    blank_n = 1'b0;  run(20, "R7 R9");
    blank_n = 1'b1; latch_en = 1'b1; run(10, "R5 R9");

    rst_n = 1'b0; tick();
    rst_n = 1'b1; dir_fwd = 1'b0; b_in = 2'b01; a_in = 2'b11;
    tick();
    cmp("R3", "reverse entry", out_en, ~(W'(1) << (CL - 1)));
    b_in = 2'b10;
    tick();
    cmp("R3", "reverse move", out_en, ~((W'(1) << (CL - 2)) | (W'(1) << (W - 1))));

    run(80, "R3 R5 R8");
    latch_en = 1'b0; run(40, "R6 R9");
    blank_n = 1'b0; latch_en = 1'b1; run(20, "R7 R9");
    blank_n = 1'b1; run(10, "R5 R9");

    for (int k = 0; k < 6; k++) begin
      dir_fwd = ~dir_fwd;
      run(12, "R2 R3 R4");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule